// File: doc/BRIEF.md
# Card Clock Phase Select Register

This block is one control register inside a storage-card host interface. It holds three 3-bit timing fields: the receive sample phase, the transmit drive phase and a clock divider value. It also holds a sticky wakeup interrupt flag. Software reads and writes the register over a plain single-register port. The read data is always present on `bus_rdata`, and a write takes effect on the clock edge where `bus_wr` is high.

Two preset timing words are fixed by parameters, one for single data rate and one for double data rate. When the bus timing mode input changes value, the register loads the preset that matches the new mode. The drive phase field also controls the command path. While that field is nonzero, every command word passing through the block leaves with its hold-register select bit set.

The clock generator, the phase delay lines and the command engine are outside this block.

Top module: `phase_sel_reg`

## Requirements
- R1: After reset, `bus_rdata` reads 0 and `wake_irq` is low. The internally tracked timing mode resets to code 2'b00.
- R2: A write loads the sample phase from `bus_wdata[2:0]`, the drive phase from `bus_wdata[18:16]` and the divider from `bus_wdata[26:24]`. The new values appear on `bus_rdata` at the same bit positions after the write's clock edge.
- R3: Every bit other than [2:0], [11], [18:16] and [26:24] reads as 0, whatever was written to it.
- R4: A one-cycle pulse on `wake_evt` sets the wakeup flag at the next edge. The flag then reads as `bus_rdata[11]` = 1, `wake_irq` is high, and both stay so until the flag is cleared.
- R5: A write with `bus_wdata[11]` = 1 clears the wakeup flag. A write with `bus_wdata[11]` = 0 leaves the flag unchanged.
- R6: Writing back the exact value just read clears a set wakeup flag and leaves all three timing fields unchanged.
- R7: When `wake_evt` and a clearing write occur in the same cycle, the flag ends up set.
- R8: `cmd_out` equals `cmd_in` with bit 29 forced to 1 while the drive phase field is nonzero. It equals `cmd_in` unchanged while that field is zero. This path is combinational.
- R9: When `timing_mode` differs from the previously seen mode, the next edge loads a preset into the three fields. Code 2'b10 (double data rate) loads the DDR preset and every other code loads the SDR preset. With the defaults, the DDR preset is sample 2, drive 3, divider 2, and the SDR preset is sample 1, drive 0, divider 2. An unchanged mode loads nothing.
- R10: A preset load takes priority over a write in the same cycle. A preset load never changes the wakeup flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current register value |
| wake_evt | input | 1 | One-cycle wakeup event pulse |
| wake_irq | output | 1 | Wakeup interrupt flag level |
| timing_mode | input | 2 | Bus timing mode code (2'b10 selects double data rate) |
| cmd_in | input | 32 | Command word from the command path |
| cmd_out | output | 32 | Command word with the hold select merged in |

## Verification
Writes, wake events and mode changes are all captured at a single clock edge. Each of their results is due on `bus_rdata` and `wake_irq` one edge after the stimulus. The bench drives these inputs at a falling edge and samples at the following falling edge, which is exactly one rising edge later. The command merge has no register in its path, so the bench checks it shortly after changing `cmd_in` within the same low phase.

// File: rtl/phase_sel_pkg.sv
package phase_sel_pkg;
  localparam int REG_W      = 32;
  localparam int FIELD_W    = 3;
  localparam int NUM_FIELDS = 3;
  // field order: 0 = sample phase, 1 = drive phase, 2 = divider
  localparam int FIELD_POS [NUM_FIELDS] = '{0, 16, 24};
  localparam int WAKE_BIT   = 11;
  localparam int HOLD_BIT   = 29;
  localparam int DRIVE_IDX  = 1;
  localparam logic [1:0] MODE_DDR  = 2'b10;
  localparam logic [1:0] MODE_RST  = 2'b00;

  function automatic logic [REG_W-1:0] pack_timing(
    input logic [FIELD_W-1:0] smp,
    input logic [FIELD_W-1:0] drv,
    input logic [FIELD_W-1:0] div);
    logic [REG_W-1:0] w;
    w = '0;
    w[FIELD_POS[0] +: FIELD_W] = smp;
    w[FIELD_POS[1] +: FIELD_W] = drv;
    w[FIELD_POS[2] +: FIELD_W] = div;
    return w;
  endfunction
endpackage

// File: rtl/psr_rst_sync.sv
module psr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/psr_fields.sv
module psr_fields
  import phase_sel_pkg::*;
#(
  parameter int NF = NUM_FIELDS,
  parameter int FW = FIELD_W,
  parameter int DW = REG_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   load_en,
  input  logic [DW-1:0]          wdata,
  input  logic [DW-1:0]          preset,
  output logic [NF-1:0][FW-1:0]  field_q
);
  for (genvar g = 0; g < NF; g++) begin : g_fld
    logic [FW-1:0] q;
    logic [FW-1:0] nxt;
    logic          en;

    always_comb begin
      en  = load_en | wr_en;
      nxt = load_en ? preset[FIELD_POS[g] +: FW] : wdata[FIELD_POS[g] +: FW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= nxt;
    end

    assign field_q[g] = q;
  end
endmodule

// File: rtl/psr_wake.sv
module psr_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic clr_req,
  output logic flag_q
);
  logic flag_d;

  // set outranks clear
  always_comb flag_d = set_pulse | (flag_q & ~clr_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/psr_cmd_merge.sv
module psr_cmd_merge #(
  parameter int DW  = 32,
  parameter int FW  = 3,
  parameter int BIT = 29
) (
  input  logic [FW-1:0] drive_phase,
  input  logic [DW-1:0] cmd_in,
  output logic [DW-1:0] cmd_out
);
  always_comb begin
    cmd_out = cmd_in;
    if (drive_phase != '0) cmd_out[BIT] = 1'b1;
  end
endmodule

// File: rtl/phase_sel_reg.sv
module phase_sel_reg
  import phase_sel_pkg::*;
#(
  parameter logic [FIELD_W-1:0] SDR_SMP = 3'd1,
  parameter logic [FIELD_W-1:0] SDR_DRV = 3'd0,
  parameter logic [FIELD_W-1:0] SDR_DIV = 3'd2,
  parameter logic [FIELD_W-1:0] DDR_SMP = 3'd2,
  parameter logic [FIELD_W-1:0] DDR_DRV = 3'd3,
  parameter logic [FIELD_W-1:0] DDR_DIV = 3'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             wake_evt,
  output logic             wake_irq,
  input  logic [1:0]       timing_mode,
  input  logic [REG_W-1:0] cmd_in,
  output logic [REG_W-1:0] cmd_out
);
  localparam logic [REG_W-1:0] SDR_WORD = pack_timing(SDR_SMP, SDR_DRV, SDR_DIV);
  localparam logic [REG_W-1:0] DDR_WORD = pack_timing(DDR_SMP, DDR_DRV, DDR_DIV);

  logic                                rst_n_i;
  logic [1:0]                          mode_q;
  logic [1:0]                          mode_d;
  logic                                mode_load;
  logic [REG_W-1:0]                    preset_word;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0]  fields;
  logic                                wake_q;

  psr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  always_comb begin
    mode_d      = timing_mode;
    mode_load   = (timing_mode != mode_q);
    preset_word = (timing_mode == MODE_DDR) ? DDR_WORD : SDR_WORD;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) mode_q <= MODE_RST;
    else          mode_q <= mode_d;
  end

  psr_fields #(.NF(NUM_FIELDS), .FW(FIELD_W), .DW(REG_W)) u_fields (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (bus_wr),
    .load_en (mode_load),
    .wdata   (bus_wdata),
    .preset  (preset_word),
    .field_q (fields)
  );

  psr_wake u_wake (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .set_pulse (wake_evt),
    .clr_req   (bus_wr & bus_wdata[WAKE_BIT]),
    .flag_q    (wake_q)
  );

  psr_cmd_merge #(.DW(REG_W), .FW(FIELD_W), .BIT(HOLD_BIT)) u_merge (
    .drive_phase (fields[DRIVE_IDX]),
    .cmd_in      (cmd_in),
    .cmd_out     (cmd_out)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_FIELDS; i++) bus_rdata[FIELD_POS[i] +: FIELD_W] = fields[i];
    bus_rdata[WAKE_BIT] = wake_q;
  end

  assign wake_irq = wake_q;
endmodule

// File: rtl/phase_sel_chk.sv
module phase_sel_chk
  import phase_sel_pkg::*;
#(
  parameter logic [FIELD_W-1:0] DDR_SMP = 3'd2,
  parameter logic [FIELD_W-1:0] DDR_DRV = 3'd3,
  parameter logic [FIELD_W-1:0] DDR_DIV = 3'd2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [REG_W-1:0] bus_wdata,
  input logic [REG_W-1:0] bus_rdata,
  input logic             wake_evt,
  input logic             wake_irq,
  input logic [1:0]       timing_mode,
  input logic [REG_W-1:0] cmd_in,
  input logic [REG_W-1:0] cmd_out
);
  localparam logic [REG_W-1:0] FMASK = pack_timing(3'h7, 3'h7, 3'h7);
  localparam logic [REG_W-1:0] DDR_W = pack_timing(DDR_SMP, DDR_DRV, DDR_DIV);

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~(FMASK | (32'h1 << WAKE_BIT))) == '0);

  p_wake_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> wake_irq);

  p_wake_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[WAKE_BIT] && !wake_evt) |=> !wake_irq);

  p_wake_irq_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq == bus_rdata[WAKE_BIT]);

  p_hold_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[18:16] != 3'd0) |-> cmd_out[HOLD_BIT]);

  p_cmd_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_out[28:0] == cmd_in[28:0] && cmd_out[31:30] == cmd_in[31:30]);

  p_ddr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_mode == MODE_DDR && !$stable(timing_mode)) |=> ((bus_rdata & FMASK) == DDR_W));
endmodule

bind phase_sel_reg phase_sel_chk #(
  .DDR_SMP(DDR_SMP), .DDR_DRV(DDR_DRV), .DDR_DIV(DDR_DIV)
) u_chk (
  .clk(clk), .rst_n(rst_n_i), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .wake_evt(wake_evt), .wake_irq(wake_irq),
  .timing_mode(timing_mode), .cmd_in(cmd_in), .cmd_out(cmd_out)
);

// File: tb/test_phase_sel_reg.sv
`timescale 1ns/1ps
module test_phase_sel_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        wake_evt;
  logic        wake_irq;
  logic [1:0]  timing_mode;
  logic [31:0] cmd_in;
  logic [31:0] cmd_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  phase_sel_reg i_phase_sel_reg (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wake_evt(wake_evt), .wake_irq(wake_irq),
    .timing_mode(timing_mode), .cmd_in(cmd_in), .cmd_out(cmd_out)
  );

  localparam logic [31:0] SDR_W = 32'h0200_0001;
  localparam logic [31:0] DDR_W = 32'h0203_0002;

  // {write data, expected read back}, R2 and R3
  localparam logic [63:0] VEC [5] = '{
    {32'hFFFF_FFFF, 32'h0707_0007},
    {32'h0000_0005, 32'h0000_0005},
    {32'h0102_0304, 32'h0102_0004},
    {32'hA5A5_A5A5, 32'h0505_0005},
    {32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk); wake_evt = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); timing_mode = m;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_wr = 1'b0; bus_wdata = '0; wake_evt = 1'b0;
    timing_mode = 2'b00; cmd_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 irq", {31'h0, wake_irq}, 32'h0);

    for (int i = 0; i < 5; i++) begin
      wr(VEC[i][63:32]);
      chk("R2/R3 vector", bus_rdata, VEC[i][31:0]);
    end

    // R8 with drive zero, then nonzero
    @(negedge clk); cmd_in = 32'h1234_5678; #1;
    chk("R8 pass", cmd_out, 32'h1234_5678);
    wr(32'h0001_0000);
    cmd_in = 32'h0; #1;
    chk("R8 hold", cmd_out, 32'h2000_0000);
    cmd_in = 32'hDFFF_FFFF; #1;
    chk("R8 hold2", cmd_out, 32'hFFFF_FFFF);

    // R4 wake set
    wr(32'h0000_0003);
    pulse_wake();
    chk("R4 rdata", bus_rdata, 32'h0000_0803);
    chk("R4 irq", {31'h0, wake_irq}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R4 sticky", bus_rdata, 32'h0000_0803);

    // R5 write with bit11=0 keeps, bit11=1 clears
    wr(32'h0000_0004);
    chk("R5 keep", bus_rdata, 32'h0000_0804);
    wr(32'h0000_0804);
    chk("R5 clear", bus_rdata, 32'h0000_0004);

    // R6 write back value read
    wr(32'h0306_0002);
    pulse_wake();
    r = bus_rdata;
    chk("R6 pre", r, 32'h0306_0802);
    wr(r);
    chk("R6 writeback", bus_rdata, 32'h0306_0002);

    // R7 set wins over clear
    @(negedge clk); bus_wr = 1'b1; bus_wdata = 32'h0000_0800; wake_evt = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0; wake_evt = 1'b0;
    chk("R7 set wins", bus_rdata, 32'h0000_0800);

    // R9 mode changes; R10 load keeps wake flag
    set_mode(2'b10);
    chk("R9 ddr load", bus_rdata, DDR_W | 32'h800);
    wr(32'h0000_0800);
    chk("R9 no reload", bus_rdata, 32'h0);
    set_mode(2'b01);
    chk("R9 sdr load", bus_rdata, SDR_W);
    wr(32'h0000_0000);
    set_mode(2'b11);
    chk("R9 sdr load code3", bus_rdata, SDR_W);

    // R10 load beats same-cycle write
    @(negedge clk); bus_wr = 1'b1; bus_wdata = 32'h0707_0007; timing_mode = 2'b10;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    chk("R10 load wins", bus_rdata, DDR_W);

    // R1 reset clears again
    pulse_wake();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 async reset", bus_rdata, 32'h0);
    timing_mode = 2'b00;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", bus_rdata, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule